// File: doc/BRIEF.md
# Three-Ones Sticky Recognizer

This block watches a single serial bit and raises a flag once that bit has been sampled high on at least three rising clock edges since reset was last released. The three high samples may be scattered among any number of low samples. Once raised, the flag stays up until the next reset.

The state is a 2-bit tally held in D flip-flops. The tally saturates in its fourth and last state, which it never leaves. This is the smallest machine that does the job. A build-time parameter selects how the four states are encoded: a plain binary count or a Gray sequence. The behaviour at the ports is the same either way. The flag is a Moore output decoded from the tally alone. Reset is asynchronous and active high.

Top module: `three_ones_detector`

## Requirements
- R1: While `rst` is high, `y` is 0. Asserting `rst` drives `y` to 0 at once, without waiting for a clock edge, and the tally returns to "none seen".
- R2: A rising edge that samples `x` = 0 leaves the tally unchanged. It does not restart the count.
- R3: Once `y` is 1 it stays 1 on every later edge until `rst` is asserted.
- R4: `y` becomes 1 right after the rising edge that samples the third high `x` since reset release. It is 0 after the first and second such edges.
- R5: The high samples that are counted need not be on consecutive edges.
- R6: Edges that occur while `rst` is high are not counted, whatever the value of `x`.
- R7: Parameter `ENC_GRAY` (0 selects binary 00→01→10→11, 1 selects Gray 00→01→11→10) changes only the internal encoding. `y` is identical for both settings, and any other value is rejected at elaboration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Asynchronous active-high reset |
| x | input | 1 | Serial bit sampled on each rising edge |
| y | output | 1 | Sticky flag: three or more high samples seen |

## Verification
Four properties are checked on every cycle outside reset:
- a low sample keeps the tally still;
- a high sample moves the tally until it saturates;
- the flag never falls;
- the flag only rises after a high sample.

The flag must also read low at every edge taken in reset. Some behaviours can only be shown by the bench's scenarios:
- the exact edge at which the flag appears, for consecutive and for scattered high samples;
- a mid-cycle reset clearing the flag with no clock edge;
- high samples taken during reset being ignored;
- the two encodings agreeing at the port.

// File: rtl/tor_pkg.sv
package tor_pkg;

   localparam int TALLY_W = 2;

   typedef logic [TALLY_W-1:0] tally_t;

   localparam tally_t TALLY_NONE = '0;

   // Saturated (absorbing) code for the selected encoding.
   function automatic tally_t tally_full(input bit gray);
      return gray ? tally_t'(2'b10) : tally_t'(2'b11);
   endfunction

endpackage

// File: rtl/tor_next.sv
module tor_next
   import tor_pkg::*;
#(
   parameter bit ENC_GRAY = 1'b0
) (
   input  tally_t cur_i,
   input  logic   hit_i,
   output tally_t nxt_o
);

   localparam tally_t FULL = tally_full(ENC_GRAY);

   tally_t step;

   generate
      if (ENC_GRAY) begin : g_gray
         // 00 -> 01 -> 11 -> 10
         assign step = {cur_i[0], ~cur_i[1]};
      end else begin : g_bin
         assign step = cur_i + tally_t'(1);
      end
   endgenerate

   always_comb begin
      if (hit_i && (cur_i != FULL)) nxt_o = step;
      else                          nxt_o = cur_i;
   end

endmodule

// File: rtl/tor_state.sv
module tor_state
   import tor_pkg::*;
(
   input  logic   clk,
   input  logic   rst,
   input  tally_t d_i,
   output tally_t q_o
);

   always_ff @(posedge clk or posedge rst) begin
      if (rst) q_o <= TALLY_NONE;
      else     q_o <= d_i;
   end

   always @(posedge clk) begin
      if (rst) begin
         assert_clear_R1: assert (q_o == TALLY_NONE)
            else $error("tally not cleared in reset");
      end
   end

endmodule

// File: rtl/tor_flag.sv
module tor_flag
   import tor_pkg::*;
#(
   parameter bit ENC_GRAY = 1'b0
) (
   input  tally_t cur_i,
   output logic   flag_o
);

   localparam tally_t FULL = tally_full(ENC_GRAY);

   assign flag_o = (cur_i == FULL);

endmodule

// File: rtl/three_ones_detector.sv
module three_ones_detector
   import tor_pkg::*;
#(
   parameter int ENC_GRAY = 0
) (
   input  logic clk,
   input  logic rst,
   input  logic x,
   output logic y
);

   generate
      if (ENC_GRAY != 0 && ENC_GRAY != 1) begin : g_bad_enc
         $error("ENC_GRAY must be 0 or 1");
      end
   endgenerate

   localparam bit GRAY_SEL = (ENC_GRAY == 1);

   tally_t tally_q;
   tally_t tally_d;

   tor_next #(.ENC_GRAY(GRAY_SEL)) u_next (
      .cur_i (tally_q),
      .hit_i (x),
      .nxt_o (tally_d)
   );

   tor_state u_state (
      .clk (clk),
      .rst (rst),
      .d_i (tally_d),
      .q_o (tally_q)
   );

   tor_flag #(.ENC_GRAY(GRAY_SEL)) u_flag (
      .cur_i  (tally_q),
      .flag_o (y)
   );

   assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
      !x |=> $stable(tally_q))
      else $error("tally moved on a low sample");

   assert_advance_R4: assert property (@(posedge clk) disable iff (rst)
      (x && !y) |=> (tally_q != $past(tally_q)))
      else $error("tally did not advance on a high sample");

   assert_sticky_R3: assert property (@(posedge clk) disable iff (rst)
      y |=> y)
      else $error("flag fell without reset");

   assert_rise_R4: assert property (@(posedge clk) disable iff (rst)
      $rose(y) |-> $past(x))
      else $error("flag rose without a high sample");

   always @(posedge clk) begin
      if (rst) begin
         assert_reset_R1: assert (!y) else $error("flag high during reset");
      end
   end

endmodule

// File: tb/tb_three_ones_detector.sv
`timescale 1ns/1ps
module tb_three_ones_detector;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic x   = 1'b0;
   logic y, y_gray;

   always #4 clk = ~clk;  // 125 MHz

   three_ones_detector dut (.clk(clk), .rst(rst), .x(x), .y(y));
   three_ones_detector #(.ENC_GRAY(1)) dut_gray (.clk(clk), .rst(rst), .x(x), .y(y_gray));

   int checks = 0;
   int failures = 0;
   int model_cnt = 0;
   bit done = 0;
   bit exp_q[$];
   string tag_q[$];

   task automatic check(input string tag, input bit act, input bit exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s: y=%0b expected=%0b at %0t", tag, act, exp, $time);
      end
   endtask

   // Driver: set inputs away from the edge, predict y after the coming edge.
   task automatic drive(input bit xv, input bit rv, input string tag);
      @(negedge clk);
      x = xv;
      rst = rv;
      if (rv) model_cnt = 0;
      else if (xv && model_cnt < 3) model_cnt++;
      exp_q.push_back(model_cnt == 3);
      tag_q.push_back(tag);
   endtask

   // Monitor: compare after each edge with any expectation queued.
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (exp_q.size() > 0) begin
            bit e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, y, e);
            check({t, "_R7"}, y_gray, e);
         end
      end
   end

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 8);
      failures++;
      $display("FAIL watchdog: run hung, actual=timeout expected=finish");
      finish_run();
   end

   initial begin
      // R1: reset state
      repeat (2) @(negedge clk);
      check("R1_reset", y, 1'b0);
      check("R1_reset_R7", y_gray, 1'b0);

      // R4: three consecutive highs
      drive(1, 0, "R4_first");
      drive(1, 0, "R4_second");
      drive(1, 0, "R4_third");
      // R3: flag sticks through lows and further highs
      for (int i = 0; i < 6; i++) drive(0, 0, "R3_hold_low");
      drive(1, 0, "R3_hold_high");
      drive(0, 0, "R3_hold_low2");

      // R1: async reset mid-cycle, no clock edge needed
      @(negedge clk);
      #1 rst = 1;
      #1;
      check("R1_async", y, 1'b0);
      check("R1_async_R7", y_gray, 1'b0);
      model_cnt = 0;
      drive(0, 1, "R1_in_reset");

      // R5/R2: scattered highs
      drive(1, 0, "R5_a");
      drive(0, 0, "R2_gap");
      drive(0, 0, "R2_gap");
      drive(1, 0, "R5_b");
      for (int i = 0; i < 20; i++) drive(0, 0, "R2_long_gap");
      drive(1, 0, "R5_c");
      drive(0, 0, "R3_after_c");

      // R6: highs during reset are ignored
      drive(1, 1, "R6_in_reset");
      drive(1, 1, "R6_in_reset");
      drive(1, 1, "R6_in_reset");
      drive(0, 0, "R6_released");
      drive(1, 0, "R6_first");
      drive(1, 0, "R6_second");
      drive(0, 0, "R6_gap");
      drive(1, 0, "R6_third");
      drive(0, 0, "R3_final");

      repeat (3) @(negedge clk);
      finish_run();
   end

endmodule